// File: doc/BRIEF.md
# Speculative Vector Config Tracker

This block keeps the vector type configuration that the decode stage hands to each vector instruction. It holds two copies. The speculative copy follows the instruction stream as it is decoded. The architectural copy follows only what has retired. Each cycle the block looks at a six-lane decode group for the first immediate-form configuration instruction (vsetvli or vsetivli). When it finds one, it decodes the vector type from the immediate field of that instruction.

Redirection recovery has two sources. A rollback walk can supply a vector type directly, or a restore pulse copies the architectural value back into the speculative copy. A register-form vsetvl only learns its vector type when it writes back. When it commits, that written-back value overrides everything else and lands in both copies. The block's one output is the speculative vector type.

Top module: `vcfg_tracker`

## Requirements
- R1: Reset sets both the speculative and the architectural copy to 9'h100. The vector type layout is bit 8 illegal flag, bit 7 mask-agnostic, bit 6 tail-agnostic, bits 5:3 element width code, bits 2:0 group multiplier code.
- R2: When `cmt_reg_valid` is high, both copies take `cmt_reg_vtype`, whatever the other inputs do.
- R3: Otherwise, when `walk_valid` is high, the speculative copy takes `walk_vtype`.
- R4: Otherwise, when `restore_arch` is high, the speculative copy takes the architectural copy.
- R5: Otherwise, when `upd_en` is high and some valid lane holds an immediate-form configuration instruction, the speculative copy takes the vector type decoded from it. In every other case it holds its value.
- R6: An instruction is immediate-form when bits 6:0 are 1010111, bits 14:12 are 111, and either bit 31 is 0 (vsetvli) or bits 31:30 are 11 (vsetivli). The vector type comes from bits 27:20. When several lanes qualify, the lowest-indexed valid lane wins. Register-form vsetvl (bits 31:30 = 10), invalid lanes and other opcodes are ignored.
- R7: An immediate whose element width code is 4 or more, or whose group multiplier code is 100, decodes to 9'h100.
- R8: When `cmt_imm_valid` is high and `cmt_reg_valid` is low, the architectural copy takes `cmt_imm_vtype`. This does not change the speculative copy.
- R9: Every update shows at `spec_vtype` after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_valid | input | LANES | Valid bit for each decode lane |
| lane_inst | input | 32*LANES | Instruction words; lane i sits in bits 32*i+31:32*i |
| upd_en | input | 1 | Allows a decode-group update this cycle |
| cmt_reg_valid | input | 1 | A register-form vsetvl commits |
| cmt_reg_vtype | input | 9 | Vector type written back by that vsetvl |
| walk_valid | input | 1 | A rollback walk supplies a vector type |
| walk_vtype | input | 9 | Vector type from the rollback walk |
| restore_arch | input | 1 | Redirect start: copy the architectural value into the speculative copy |
| cmt_imm_valid | input | 1 | An immediate-form configuration instruction commits |
| cmt_imm_vtype | input | 9 | Vector type of that committing instruction |
| spec_vtype | output | 9 | Speculative vector type |

## Verification
The assertions assume that `upd_en` is already low whenever the decode group must not update, for example because of an exception. The block gates only on lane valid bits and on the higher-priority events. The stimulus keeps to that rule by driving `upd_en` high only on groups that are free of exceptions.

The assertions also assume that all inputs are stable and known while reset is low. The bench changes inputs only on the falling clock edge and leaves no signal undriven.

Several events can arrive in the same cycle, even though a real pipeline would not produce some of those combinations. The stimulus does combine them on purpose, so that the priority order itself is observed.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    localparam int INST_W = 32;
    localparam int VT_W   = 9;

    localparam logic [6:0] OPC_VEC = 7'b1010111;
    localparam logic [2:0] F3_CFG  = 3'b111;

    typedef struct packed {
        logic       vill;
        logic       vma;
        logic       vta;
        logic [2:0] vsew;
        logic [2:0] vlmul;
    } vtype_t;

    localparam vtype_t VTYPE_ILLEGAL = '{vill: 1'b1, vma: 1'b0, vta: 1'b0,
                                         vsew: 3'd0, vlmul: 3'd0};

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_REG_COMMIT,
        SRC_WALK,
        SRC_ARCH,
        SRC_DECODE
    } spec_src_e;

    // Decode the low eight immediate bits into a vector type; reserved codes give illegal.
    function automatic vtype_t zimm_to_vtype(input logic [7:0] z);
        vtype_t r;
        logic   bad;
        bad = z[5] | (z[2:0] == 3'b100);
        if (bad) begin
            r = VTYPE_ILLEGAL;
        end else begin
            r.vill  = 1'b0;
            r.vma   = z[7];
            r.vta   = z[6];
            r.vsew  = z[5:3];
            r.vlmul = z[2:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/vcfg_lane_decode.sv
module vcfg_lane_decode
    import vcfg_pkg::*;
(
    input  logic              valid,
    input  logic [INST_W-1:0] inst,
    output logic              hit,
    output vtype_t            vt
);

    logic is_cfg;
    logic is_imm_vl;
    logic is_imm_ivl;
    logic unused_fields;

    always_comb begin
        is_cfg     = (inst[6:0] == OPC_VEC) && (inst[14:12] == F3_CFG);
        is_imm_vl  = is_cfg && !inst[31];
        is_imm_ivl = is_cfg && (inst[31:30] == 2'b11);
        hit        = valid && (is_imm_vl || is_imm_ivl);
        vt         = zimm_to_vtype(inst[27:20]);
    end

    assign unused_fields = ^{inst[29:28], inst[19:15], inst[11:7]};

endmodule

// File: rtl/vcfg_first_pick.sv
module vcfg_first_pick
    import vcfg_pkg::*;
#(
    parameter int LANES = 6
) (
    input  logic [LANES-1:0] hit,
    input  vtype_t           vt [LANES],
    output logic             any,
    output vtype_t           sel
);

    always_comb begin
        any = |hit;
        sel = VTYPE_ILLEGAL;
        // Walk downward so the lowest qualifying lane is assigned last.
        for (int i = LANES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel = vt[i];
            end
        end
    end

endmodule

// File: rtl/vcfg_next_sel.sv
module vcfg_next_sel
    import vcfg_pkg::*;
(
    input  logic   cmt_reg_valid,
    input  vtype_t cmt_reg_vtype,
    input  logic   walk_valid,
    input  vtype_t walk_vtype,
    input  logic   restore_arch,
    input  logic   grp_take,
    input  vtype_t grp_vtype,
    input  logic   cmt_imm_valid,
    input  vtype_t cmt_imm_vtype,
    input  vtype_t spec_q,
    input  vtype_t arch_q,
    output vtype_t spec_d,
    output vtype_t arch_d
);

    spec_src_e src;

    always_comb begin
        if (cmt_reg_valid)     src = SRC_REG_COMMIT;
        else if (walk_valid)   src = SRC_WALK;
        else if (restore_arch) src = SRC_ARCH;
        else if (grp_take)     src = SRC_DECODE;
        else                   src = SRC_HOLD;

        unique case (src)
            SRC_REG_COMMIT: spec_d = cmt_reg_vtype;
            SRC_WALK:       spec_d = walk_vtype;
            SRC_ARCH:       spec_d = arch_q;
            SRC_DECODE:     spec_d = grp_vtype;
            default:        spec_d = spec_q;
        endcase

        if (cmt_reg_valid)      arch_d = cmt_reg_vtype;
        else if (cmt_imm_valid) arch_d = cmt_imm_vtype;
        else                    arch_d = arch_q;
    end

endmodule

// File: rtl/vcfg_tracker.sv
module vcfg_tracker
    import vcfg_pkg::*;
#(
    parameter int LANES = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        lane_valid,
    input  logic [INST_W*LANES-1:0] lane_inst,
    input  logic                    upd_en,
    input  logic                    cmt_reg_valid,
    input  logic [VT_W-1:0]         cmt_reg_vtype,
    input  logic                    walk_valid,
    input  logic [VT_W-1:0]         walk_vtype,
    input  logic                    restore_arch,
    input  logic                    cmt_imm_valid,
    input  logic [VT_W-1:0]         cmt_imm_vtype,
    output logic [VT_W-1:0]         spec_vtype
);

    logic [LANES-1:0] lane_hit;
    vtype_t           lane_vt [LANES];
    logic             grp_hit;
    vtype_t           grp_vtype;
    vtype_t           spec_q, spec_d;
    vtype_t           arch_q, arch_d;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vcfg_lane_decode u_dec (
            .valid (lane_valid[g]),
            .inst  (lane_inst[g*INST_W +: INST_W]),
            .hit   (lane_hit[g]),
            .vt    (lane_vt[g])
        );
    end

    vcfg_first_pick #(.LANES(LANES)) u_pick (
        .hit (lane_hit),
        .vt  (lane_vt),
        .any (grp_hit),
        .sel (grp_vtype)
    );

    vcfg_next_sel u_next (
        .cmt_reg_valid (cmt_reg_valid),
        .cmt_reg_vtype (vtype_t'(cmt_reg_vtype)),
        .walk_valid    (walk_valid),
        .walk_vtype    (vtype_t'(walk_vtype)),
        .restore_arch  (restore_arch),
        .grp_take      (grp_hit && upd_en),
        .grp_vtype     (grp_vtype),
        .cmt_imm_valid (cmt_imm_valid),
        .cmt_imm_vtype (vtype_t'(cmt_imm_vtype)),
        .spec_q        (spec_q),
        .arch_q        (arch_q),
        .spec_d        (spec_d),
        .arch_d        (arch_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_q <= VTYPE_ILLEGAL;
            arch_q <= VTYPE_ILLEGAL;
        end else begin
            spec_q <= spec_d;
            arch_q <= arch_d;
        end
    end

    assign spec_vtype = spec_q;

endmodule

// File: rtl/vcfg_tracker_chk.sv
module vcfg_tracker_chk
    import vcfg_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            upd_en,
    input logic            cmt_reg_valid,
    input logic [VT_W-1:0] cmt_reg_vtype,
    input logic            walk_valid,
    input logic [VT_W-1:0] walk_vtype,
    input logic            restore_arch,
    input logic            cmt_imm_valid,
    input logic [VT_W-1:0] cmt_imm_vtype,
    input logic            grp_hit,
    input logic [VT_W-1:0] pick_vtype,
    input logic [VT_W-1:0] arch_vtype,
    input logic [VT_W-1:0] spec_vtype
);

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (spec_vtype == 9'h100 && arch_vtype == 9'h100));

    assert_reg_commit_R2: assert property (@(posedge clk) disable iff (rst)
        cmt_reg_valid |=> (spec_vtype == $past(cmt_reg_vtype) && arch_vtype == $past(cmt_reg_vtype)));

    assert_walk_R3: assert property (@(posedge clk) disable iff (rst)
        (!cmt_reg_valid && walk_valid) |=> spec_vtype == $past(walk_vtype));

    assert_restore_R4: assert property (@(posedge clk) disable iff (rst)
        (!cmt_reg_valid && !walk_valid && restore_arch) |=> spec_vtype == $past(arch_vtype));

    assert_group_take_R5: assert property (@(posedge clk) disable iff (rst)
        (!cmt_reg_valid && !walk_valid && !restore_arch && upd_en && grp_hit)
        |=> spec_vtype == $past(pick_vtype));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!cmt_reg_valid && !walk_valid && !restore_arch && !(upd_en && grp_hit))
        |=> $stable(spec_vtype));

    assert_illegal_clean_R7: assert property (@(posedge clk) disable iff (rst)
        pick_vtype[8] |-> pick_vtype[7:0] == 8'h00);

    assert_imm_commit_R8: assert property (@(posedge clk) disable iff (rst)
        (cmt_imm_valid && !cmt_reg_valid) |=> arch_vtype == $past(cmt_imm_vtype));

endmodule

bind vcfg_tracker vcfg_tracker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .upd_en        (upd_en),
    .cmt_reg_valid (cmt_reg_valid),
    .cmt_reg_vtype (cmt_reg_vtype),
    .walk_valid    (walk_valid),
    .walk_vtype    (walk_vtype),
    .restore_arch  (restore_arch),
    .cmt_imm_valid (cmt_imm_valid),
    .cmt_imm_vtype (cmt_imm_vtype),
    .grp_hit       (grp_hit),
    .pick_vtype    (grp_vtype),
    .arch_vtype    (arch_q),
    .spec_vtype    (spec_vtype)
);

// File: tb/tb_vcfg_tracker.sv
module tb_vcfg_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 6;
    localparam int NVEC       = 18;
    localparam logic [31:0] NOP = 32'h0000_0013;

    typedef struct packed {
        logic [5:0]   vld;
        logic [191:0] ins;   // lane 5 .. lane 0
        logic         upd;
        logic         creg;
        logic [8:0]   creg_vt;
        logic         wv;
        logic [8:0]   wvt;
        logic         rs;
        logic         cimm;
        logic [8:0]   cimm_vt;
        logic [8:0]   exp_spec;
        logic [3:0]   req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // R5 vsetvli in lane 2, update allowed
        '{6'b000100, {NOP, NOP, NOP, 32'h0D10_7057, NOP, NOP}, 1'b1, 1'b0, 9'h0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, 9'h0D1, 4'd5},
        // R5 update not allowed: hold
        '{6'b111111, {NOP, NOP, NOP, NOP, NOP, 32'hC080_7057}, 1'b0, 1'b0, 9'h0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, 9'h0D1, 4'd5},
        // R6 two vsets, lane 1 wins over lane 4
        '{6'b111111, {NOP, 32'h0080_7057, NOP, NOP, 32'hC1A0_7057, NOP}, 1'b1, 1'b0, 9'h0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, 9'h01A, 4'd6},
        // R6 invalid lane 0 skipped, lane 3 taken
        '{6'b001000, {NOP, NOP, 32'hC090_7057, NOP, NOP, 32'h0C00_7057}, 1'b1, 1'b0, 9'h0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, 9'h009, 4'd6},
        // R7 reserved element width
        '{6'b100000, {32'h0200_7057, NOP, NOP, NOP, NOP, NOP}, 1'b1, 1'b0, 9'h0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, 9'h100, 4'd7},
        // R7 reserved group multiplier
        '{6'b000001, {NOP, NOP, NOP, NOP, NOP, 32'hC4C0_7057}, 1'b1, 1'b0, 9'h0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, 9'h100, 4'd7},
        // R5 legal again
        '{6'b000001, {NOP, NOP, NOP, NOP, NOP, 32'h0C30_7057}, 1'b1, 1'b0, 9'h0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, 9'h0C3, 4'd5},
        // R3 walk beats decode
        '{6'b000001, {NOP, NOP, NOP, NOP, NOP, 32'h0080_7057}, 1'b1, 1'b0, 9'h0, 1'b1, 9'h05A, 1'b0, 1'b0, 9'h0, 9'h05A, 4'd3},
        // R3 walk beats restore
        '{6'b000000, {NOP, NOP, NOP, NOP, NOP, NOP}, 1'b0, 1'b0, 9'h0, 1'b1, 9'h011, 1'b1, 1'b0, 9'h0, 9'h011, 4'd3},
        // R4 restore beats decode, arch still reset value
        '{6'b000001, {NOP, NOP, NOP, NOP, NOP, 32'h0080_7057}, 1'b1, 1'b0, 9'h0, 1'b0, 9'h0, 1'b1, 1'b0, 9'h0, 9'h100, 4'd4},
        // R8 immediate commit leaves speculative copy alone
        '{6'b000000, {NOP, NOP, NOP, NOP, NOP, NOP}, 1'b0, 1'b0, 9'h0, 1'b0, 9'h0, 1'b0, 1'b1, 9'h0D2, 9'h100, 4'd8},
        // R8 restore shows committed value
        '{6'b000000, {NOP, NOP, NOP, NOP, NOP, NOP}, 1'b0, 1'b0, 9'h0, 1'b0, 9'h0, 1'b1, 1'b0, 9'h0, 9'h0D2, 4'd8},
        // R2 register commit beats all
        '{6'b000001, {NOP, NOP, NOP, NOP, NOP, 32'h0080_7057}, 1'b1, 1'b1, 9'h01B, 1'b1, 9'h044, 1'b1, 1'b0, 9'h0, 9'h01B, 4'd2},
        // R6 register-form vsetvl in lane 0 ignored, lane 1 taken
        '{6'b000011, {NOP, NOP, NOP, NOP, 32'hC0A0_7057, 32'h8000_7057}, 1'b1, 1'b0, 9'h0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, 9'h00A, 4'd6},
        // R2 arch took register commit
        '{6'b000000, {NOP, NOP, NOP, NOP, NOP, NOP}, 1'b0, 1'b0, 9'h0, 1'b0, 9'h0, 1'b1, 1'b0, 9'h0, 9'h01B, 4'd2},
        // R8 immediate commit, speculative copy held
        '{6'b000000, {NOP, NOP, NOP, NOP, NOP, NOP}, 1'b0, 1'b0, 9'h0, 1'b0, 9'h0, 1'b0, 1'b1, 9'h033, 9'h01B, 4'd8},
        // R8 restore shows it
        '{6'b000000, {NOP, NOP, NOP, NOP, NOP, NOP}, 1'b0, 1'b0, 9'h0, 1'b0, 9'h0, 1'b1, 1'b0, 9'h0, 9'h033, 4'd8},
        // R6 other vector opcode ignored
        '{6'b000001, {NOP, NOP, NOP, NOP, NOP, 32'h0D10_0057}, 1'b1, 1'b0, 9'h0, 1'b0, 9'h0, 1'b0, 1'b0, 9'h0, 9'h033, 4'd6}
    };

    logic                 clk = 1'b0;
    logic                 rst;
    logic [LANES-1:0]     lane_valid;
    logic [32*LANES-1:0]  lane_inst;
    logic                 upd_en;
    logic                 cmt_reg_valid;
    logic [8:0]           cmt_reg_vtype;
    logic                 walk_valid;
    logic [8:0]           walk_vtype;
    logic                 restore_arch;
    logic                 cmt_imm_valid;
    logic [8:0]           cmt_imm_vtype;
    logic [8:0]           spec_vtype;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vcfg_tracker #(.LANES(LANES)) dut (
        .clk           (clk),
        .rst           (rst),
        .lane_valid    (lane_valid),
        .lane_inst     (lane_inst),
        .upd_en        (upd_en),
        .cmt_reg_valid (cmt_reg_valid),
        .cmt_reg_vtype (cmt_reg_vtype),
        .walk_valid    (walk_valid),
        .walk_vtype    (walk_vtype),
        .restore_arch  (restore_arch),
        .cmt_imm_valid (cmt_imm_valid),
        .cmt_imm_vtype (cmt_imm_vtype),
        .spec_vtype    (spec_vtype)
    );

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        lane_valid    = '0;
        lane_inst     = {LANES{NOP}};
        upd_en        = 1'b0;
        cmt_reg_valid = 1'b0;
        cmt_reg_vtype = '0;
        walk_valid    = 1'b0;
        walk_vtype    = '0;
        restore_arch  = 1'b0;
        cmt_imm_valid = 1'b0;
        cmt_imm_vtype = '0;
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset value
        check("R1 reset", spec_vtype, 9'h100);

        for (int i = 0; i < NVEC; i++) begin
            lane_valid    = VECS[i].vld;
            lane_inst     = VECS[i].ins;
            upd_en        = VECS[i].upd;
            cmt_reg_valid = VECS[i].creg;
            cmt_reg_vtype = VECS[i].creg_vt;
            walk_valid    = VECS[i].wv;
            walk_vtype    = VECS[i].wvt;
            restore_arch  = VECS[i].rs;
            cmt_imm_valid = VECS[i].cimm;
            cmt_imm_vtype = VECS[i].cimm_vt;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), spec_vtype, VECS[i].exp_spec);
        end
        idle();

        // R9 no change before the edge, change after it
        walk_valid = 1'b1;
        walk_vtype = 9'h0AB;
        #(CLK_PERIOD / 4);
        check("R9 before edge", spec_vtype, 9'h033);
        @(posedge clk);
        @(negedge clk);
        check("R9 after edge", spec_vtype, 9'h0AB);
        idle();

        // R1 mid-run reset clears both copies
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset speculative", spec_vtype, 9'h100);
        restore_arch = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset architectural", spec_vtype, 9'h100);
        idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R9 watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule